// File: doc/BRIEF.md
# Sequence-Locked Snapshot Trigger and Coherent Averager

This block sits on the receive side of a correlation channel sounder, on the sampling clock that is derived from the shared frequency reference. It counts the valid samples of the incoming signed I/Q stream. After every `intv_per × seq_len` valid samples it raises a one-cycle trigger, so snapshots stay aligned to the repeating transmit sequence.

An accepted trigger starts a snapshot. The block adds up `2^avg_log2` consecutive sequence periods position by position: the sample at index n of each period goes into its own accumulator. During the last period it writes the rounded mean of each index to snapshot memory. Snapshots fill the memory one after another. A done pulse and a snapshot count mark each finished one. A trigger that arrives while averaging is still running is dropped and counted as an overrun. When the memory has no room left for another snapshot, capture stops and a full flag stays set until reset.

Neither data stream carries a ready signal. The sample input follows the converter, which cannot be stalled. A cycle with `in_valid` low is simply skipped. The write port drives a memory that accepts one write in every cycle, so `wr_valid` never waits.

Top module: `snap_avg`

## Requirements
- R1: `trig` is high for exactly the cycle of the first valid sample after `run` rises and of every `intv_per*seq_len`-th valid sample after that. While `run` is low, `trig` stays low and the interval count is held at zero.
- R2: Cycles with `in_valid` low advance neither the interval count nor the averaging position, and their sample values have no effect on stored results.
- R3: A snapshot begins with the sample that carries an accepted trigger and spans M = 2^`avg_log2` consecutive periods. The result for index n is formed from the sum of the samples at index n of each of those periods. The I and Q parts are handled separately.
- R4: Each stored value is (sum + 2^(avg_log2-1)) arithmetically shifted right by `avg_log2`, which rounds half toward plus infinity (for example, 1 and 2 give 2; -1 and -2 give -1). When `avg_log2` is 0, the input samples are stored unchanged.
- R5: A snapshot produces exactly `seq_len` writes, one for each sample of the final period. Each write comes one cycle after its sample. The addresses are consecutive, starting at `k*seq_len` for the k-th snapshot (counting from 0).
- R6: `snap_done` is high for one cycle, together with the last write of a snapshot. `snap_cnt` increases by one on the clock edge that ends that cycle.
- R7: A trigger that arrives while a snapshot is still averaging starts nothing, and it increments `ovr_cnt` by one.
- R8: A snapshot starts only if `seq_len` more entries still fit in the `DEPTH`-entry memory. Once the last snapshot that fits has finished, `mem_full` rises and stays high. After that, triggers cause no writes and no overrun counts.
- R9: After reset, `trig`, `wr_valid`, `snap_done`, `mem_full`, `snap_cnt` and `ovr_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock derived from the shared reference |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables interval counting and triggering |
| seq_len | input | LEN_W | Sequence period in samples (1..MAX_LEN) |
| intv_per | input | IVW | Trigger interval in sequence periods (>=1) |
| avg_log2 | input | KW | log2 of the number of averaged periods (0..MAX_LOG) |
| in_valid | input | 1 | Sample strobe |
| in_i | input | SW | Signed in-phase sample |
| in_q | input | SW | Signed quadrature sample |
| trig | output | 1 | One-cycle capture trigger |
| wr_valid | output | 1 | Snapshot memory write strobe |
| wr_addr | output | AW_MEM | Snapshot memory write address |
| wr_i | output | SW | Averaged in-phase value |
| wr_q | output | SW | Averaged quadrature value |
| snap_done | output | 1 | High with the final write of a snapshot |
| snap_cnt | output | CW | Completed snapshots |
| ovr_cnt | output | CW | Triggers dropped while averaging |
| mem_full | output | 1 | Sticky: no room for another snapshot |

## Verification
The assertions assume that `seq_len`, `intv_per` and `avg_log2` are held constant while `run` is high or a snapshot is in progress, that `seq_len` does not exceed `MAX_LEN` and `intv_per` is at least one. The interval bound and the address range depend on this. The stimulus sets each configuration while in reset with `run` low, and then only streams samples. Every configuration uses lengths that fit the memory. Idle cycles carry deliberately different sample values, so a design that uses them produces wrong averages.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_AVG  = 1'b1
  } avg_state_e;
endpackage

// File: rtl/snap_trig.sv
module snap_trig #(
  parameter int LEN_W = 5,
  parameter int IVW   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] seq_len,
  input  logic [IVW-1:0]   intv_per,
  output logic             trig
);
  localparam int CNT_W = LEN_W + IVW;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = CNT_W'(intv_per) * CNT_W'(seq_len) - CNT_W'(1);
  assign trig = run & in_valid & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (in_valid)  cnt <= (cnt == lim) ? '0 : cnt + CNT_W'(1);
  end

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= lim));
endmodule

// File: rtl/snap_accum.sv
module snap_accum
  import snap_pkg::*;
#(
  parameter int SW      = 8,
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5,
  parameter int MAX_LOG = 3,
  parameter int KW      = 2,
  parameter int CW      = 16,
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trig,
  input  logic                 halt,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  input  logic [LEN_W-1:0]     seq_len,
  input  logic [KW-1:0]        avg_log2,
  output logic                 start_o,
  output logic                 o_valid,
  output logic [IDX_W-1:0]     o_idx,
  output logic signed [SW-1:0] o_i,
  output logic signed [SW-1:0] o_q,
  output logic                 o_last,
  output logic [CW-1:0]        ovr_cnt
);
  localparam int ACC_W = SW + MAX_LOG + 1;
  localparam int PER_W = MAX_LOG + 1;

  avg_state_e st;
  logic [IDX_W-1:0] idx, cur_idx;
  logic [PER_W-1:0] per, cur_per, per_lim;
  logic signed [ACC_W-1:0] acc_i [MAX_LEN];
  logic signed [ACC_W-1:0] acc_q [MAX_LEN];
  logic signed [ACC_W-1:0] sum_i, sum_q, rnd, avg_i, avg_q;
  logic start, take, last_per, end_idx;

  assign start    = trig & (st == ST_IDLE) & ~halt;
  assign take     = in_valid & (start | (st == ST_AVG));
  assign cur_idx  = start ? '0 : idx;
  assign cur_per  = start ? '0 : per;
  assign per_lim  = ~({PER_W{1'b1}} << avg_log2);
  assign last_per = (cur_per == per_lim);
  assign end_idx  = (LEN_W'(cur_idx) == seq_len - LEN_W'(1));
  assign start_o  = start;

  // first period overwrites, later periods add
  assign sum_i = ((cur_per == '0) ? '0 : acc_i[cur_idx]) + ACC_W'(in_i);
  assign sum_q = ((cur_per == '0) ? '0 : acc_q[cur_idx]) + ACC_W'(in_q);
  assign rnd   = (avg_log2 == '0) ? '0 : (ACC_W'(1) << (avg_log2 - KW'(1)));
  assign avg_i = (sum_i + rnd) >>> avg_log2;
  assign avg_q = (sum_q + rnd) >>> avg_log2;

  always_ff @(posedge clk) begin
    if (take) begin
      acc_i[cur_idx] <= sum_i;
      acc_q[cur_idx] <= sum_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      idx     <= '0;
      per     <= '0;
      o_valid <= 1'b0;
      o_last  <= 1'b0;
      o_idx   <= '0;
      o_i     <= '0;
      o_q     <= '0;
      ovr_cnt <= '0;
    end else begin
      o_valid <= take & last_per;
      o_last  <= take & last_per & end_idx;
      if (take) begin
        o_idx <= cur_idx;
        o_i   <= avg_i[SW-1:0];
        o_q   <= avg_q[SW-1:0];
        if (end_idx) begin
          idx <= '0;
          if (last_per) begin
            st  <= ST_IDLE;
            per <= '0;
          end else begin
            st  <= ST_AVG;
            per <= cur_per + PER_W'(1);
          end
        end else begin
          st  <= ST_AVG;
          idx <= cur_idx + IDX_W'(1);
          per <= cur_per;
        end
      end
      if (trig && st == ST_AVG) ovr_cnt <= ovr_cnt + CW'(1);
    end
  end

  // R7
  ovr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ovr_cnt) |-> $past(trig && st == ST_AVG));
  // R3
  per_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_AVG) |-> (per <= per_lim));
endmodule

// File: rtl/snap_store.sv
module snap_store #(
  parameter int SW     = 8,
  parameter int LEN_W  = 5,
  parameter int IDX_W  = 4,
  parameter int DEPTH  = 64,
  parameter int AW_MEM = 6,
  parameter int CW     = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEN_W-1:0]      seq_len,
  input  logic                  o_valid,
  input  logic [IDX_W-1:0]      o_idx,
  input  logic signed [SW-1:0]  o_i,
  input  logic signed [SW-1:0]  o_q,
  input  logic                  o_last,
  output logic                  no_room,
  output logic                  wr_valid,
  output logic [AW_MEM-1:0]     wr_addr,
  output logic signed [SW-1:0]  wr_i,
  output logic signed [SW-1:0]  wr_q,
  output logic                  snap_done,
  output logic [CW-1:0]         snap_cnt,
  output logic                  full
);
  localparam int BASE_W = $clog2(DEPTH + 1);
  localparam int CMP_W  = ((BASE_W > LEN_W) ? BASE_W : LEN_W) + 1;

  logic [BASE_W-1:0] free_ptr, wbase;

  assign no_room   = (CMP_W'(free_ptr) + CMP_W'(seq_len)) > CMP_W'(DEPTH);
  assign wr_valid  = o_valid;
  assign wr_addr   = AW_MEM'(wbase + BASE_W'(o_idx));
  assign wr_i      = o_i;
  assign wr_q      = o_q;
  assign snap_done = o_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_ptr <= '0;
      wbase    <= '0;
      snap_cnt <= '0;
      full     <= 1'b0;
    end else begin
      if (start) begin
        wbase    <= free_ptr;
        free_ptr <= free_ptr + BASE_W'(seq_len);
      end
      if (o_last) begin
        snap_cnt <= snap_cnt + CW'(1);
        if (no_room) full <= 1'b1;
      end
    end
  end

  // R8
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (CMP_W'(wbase) + CMP_W'(o_idx) < CMP_W'(DEPTH)));
  // R8
  full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
  // R8
  no_write_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !wr_valid);
  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(snap_cnt) |-> $past(snap_done && wr_valid));
endmodule

// File: rtl/snap_avg.sv
module snap_avg #(
  parameter int SW      = 8,
  parameter int MAX_LEN = 16,
  parameter int IVW     = 8,
  parameter int MAX_LOG = 3,
  parameter int DEPTH   = 64,
  parameter int CW      = 16,
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int KW     = $clog2(MAX_LOG + 1),
  localparam int AW_MEM = $clog2(DEPTH),
  localparam int IDX_W  = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [LEN_W-1:0]     seq_len,
  input  logic [IVW-1:0]       intv_per,
  input  logic [KW-1:0]        avg_log2,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] in_i,
  input  logic signed [SW-1:0] in_q,
  output logic                 trig,
  output logic                 wr_valid,
  output logic [AW_MEM-1:0]    wr_addr,
  output logic signed [SW-1:0] wr_i,
  output logic signed [SW-1:0] wr_q,
  output logic                 snap_done,
  output logic [CW-1:0]        snap_cnt,
  output logic [CW-1:0]        ovr_cnt,
  output logic                 mem_full
);
  logic                 start, no_room, a_valid, a_last;
  logic [IDX_W-1:0]     a_idx;
  logic signed [SW-1:0] a_i, a_q;

  snap_trig #(.LEN_W(LEN_W), .IVW(IVW)) u_trig (
    .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid),
    .seq_len(seq_len), .intv_per(intv_per), .trig(trig)
  );

  snap_accum #(.SW(SW), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .MAX_LOG(MAX_LOG),
               .KW(KW), .CW(CW)) u_accum (
    .clk(clk), .rst_n(rst_n), .trig(trig), .halt(no_room),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .seq_len(seq_len), .avg_log2(avg_log2), .start_o(start),
    .o_valid(a_valid), .o_idx(a_idx), .o_i(a_i), .o_q(a_q),
    .o_last(a_last), .ovr_cnt(ovr_cnt)
  );

  snap_store #(.SW(SW), .LEN_W(LEN_W), .IDX_W(IDX_W), .DEPTH(DEPTH),
               .AW_MEM(AW_MEM), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_len(seq_len),
    .o_valid(a_valid), .o_idx(a_idx), .o_i(a_i), .o_q(a_q), .o_last(a_last),
    .no_room(no_room), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_i(wr_i), .wr_q(wr_q), .snap_done(snap_done),
    .snap_cnt(snap_cnt), .full(mem_full)
  );
endmodule

// File: tb/snap_avg_bench.sv
`timescale 1ns/1ps
module snap_avg_bench;
  localparam int DEPTH = 64;
  localparam int ROWS  = 4;
  // seq_len, interval periods, avg_log2, periods streamed, insert gaps
  localparam int VEC [ROWS][5] = '{
    '{4, 2, 1, 8, 0},
    '{8, 1, 2, 12, 1},
    '{16, 3, 0, 20, 0},
    '{5, 3, 3, 16, 1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [4:0] seq_len = '0;
  logic [7:0] intv_per = '0;
  logic [1:0] avg_log2 = '0;
  logic in_valid = 1'b0;
  logic signed [7:0] in_i = '0, in_q = '0;
  logic trig, wr_valid, snap_done, mem_full;
  logic [5:0] wr_addr;
  logic signed [7:0] wr_i, wr_q;
  logic [15:0] snap_cnt, ovr_cnt;

  snap_avg u_snap_avg (
    .clk(clk), .rst_n(rst_n), .run(run), .seq_len(seq_len),
    .intv_per(intv_per), .avg_log2(avg_log2), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .trig(trig), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_i(wr_i), .wr_q(wr_q), .snap_done(snap_done),
    .snap_cnt(snap_cnt), .ovr_cnt(ovr_cnt), .mem_full(mem_full)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int trig_seen = 0, wr_seen = 0, done_seen = 0;
  logic signed [7:0] bm_i [DEPTH];
  logic signed [7:0] bm_q [DEPTH];

  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      bm_i[wr_addr] = wr_i;
      bm_q[wr_addr] = wr_q;
      wr_seen++;
    end
    if (rst_n && snap_done) done_seen++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gen_i(int t, int n);
    int v;
    v = (n * 37 + t * 23 + 5) % 256;
    return (v >= 128) ? v - 256 : v;
  endfunction

  function automatic int gen_q(int t, int n);
    int v;
    v = ((n * 11 - t * 53 + 200) % 256 + 256) % 256;
    return (v >= 128) ? v - 256 : v;
  endfunction

  task automatic send(input int i, input int q);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 8'(i);
    in_q = 8'(q);
    #1;
    if (trig) trig_seen++;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    in_i = 8'sd99;
    in_q = -8'sd77;
    #1;
    if (trig) trig_seen++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    run = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      bm_i[a] = '0;
      bm_q[a] = '0;
    end
    trig_seen = 0;
    wr_seen = 0;
    done_seen = 0;
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int nl, iv, k, tp, gp, m, busy_to, started, completed, ovr, trigs, cnt, sum, e;
    int st_per [32];

    // R9 reset state
    do_reset();
    chk("R9 trig", int'(trig), 0);
    chk("R9 wr_valid", int'(wr_valid), 0);
    chk("R9 snap_done", int'(snap_done), 0);
    chk("R9 mem_full", int'(mem_full), 0);
    chk("R9 snap_cnt", int'(snap_cnt), 0);
    chk("R9 ovr_cnt", int'(ovr_cnt), 0);

    for (int r = 0; r < ROWS; r++) begin
      nl = VEC[r][0]; iv = VEC[r][1]; k = VEC[r][2]; tp = VEC[r][3]; gp = VEC[r][4];
      m = 1 << k;
      busy_to = 0; started = 0; completed = 0; ovr = 0; trigs = 0;
      for (int t = 0; t < tp; t++) begin
        if (t % iv == 0) begin
          trigs++;
          if (t < busy_to) ovr++;
          else if ((started + 1) * nl <= DEPTH) begin
            st_per[started] = t;
            started++;
            busy_to = t + m;
            if (t + m <= tp) completed++;
          end
        end
      end
      do_reset();
      seq_len = 5'(nl);
      intv_per = 8'(iv);
      avg_log2 = 2'(k);
      run = 1'b1;
      cnt = 0;
      for (int t = 0; t < tp; t++) begin
        for (int n = 0; n < nl; n++) begin
          if (gp != 0 && cnt % 3 == 1) idle();
          send(gen_i(t, n), gen_q(t, n));
          cnt++;
        end
      end
      repeat (5) idle();
      chk($sformatf("R1 row%0d trigger count", r), trig_seen, trigs);
      chk($sformatf("R7 row%0d overrun count", r), int'(ovr_cnt), ovr);
      chk($sformatf("R6 row%0d snapshot count", r), int'(snap_cnt), completed);
      chk($sformatf("R6 row%0d done pulses", r), done_seen, completed);
      chk($sformatf("R5 row%0d write count", r), wr_seen, completed * nl);
      chk($sformatf("R8 row%0d full flag", r),
          int'(mem_full), ((started + 1) * nl > DEPTH && completed == started) ? 1 : 0);
      for (int j = 0; j < completed; j++) begin
        for (int n = 0; n < nl; n++) begin
          sum = 0;
          for (int p = 0; p < m; p++) sum += gen_i(st_per[j] + p, n);
          e = (sum + ((k > 0) ? (1 << (k - 1)) : 0)) >>> k;
          chk($sformatf("R3 R4 R2 row%0d snap%0d idx%0d I", r, j, n), int'(bm_i[j * nl + n]), e);
          sum = 0;
          for (int p = 0; p < m; p++) sum += gen_q(st_per[j] + p, n);
          e = (sum + ((k > 0) ? (1 << (k - 1)) : 0)) >>> k;
          chk($sformatf("R3 R4 R2 row%0d snap%0d idx%0d Q", r, j, n), int'(bm_q[j * nl + n]), e);
        end
      end
    end

    // R4 rounding and extremes, R6 done timing
    do_reset();
    seq_len = 5'd2;
    intv_per = 8'd2;
    avg_log2 = 2'd1;
    run = 1'b1;
    send(1, -128);
    send(-1, 127);
    send(2, -128);
    send(-2, 127);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R6 done with last write", int'(snap_done), 1);
    chk("R5 last write address", int'(wr_addr), 1);
    chk("R6 count before edge", int'(snap_cnt), 0);
    @(negedge clk);
    chk("R6 count after edge", int'(snap_cnt), 1);
    chk("R6 done single cycle", int'(snap_done), 0);
    chk("R4 half-up positive", int'(bm_i[0]), 2);
    chk("R4 half-up negative", int'(bm_i[1]), -1);
    chk("R4 minimum kept", int'(bm_q[0]), -128);
    chk("R4 maximum kept", int'(bm_q[1]), 127);
    chk("R1 single trigger", trig_seen, 1);

    summary();
    $finish;
  end
endmodule